// File: doc/BRIEF.md
# Synchronous burst address generator

This block produces the word address presented to a synchronous burst memory. On a burst start it captures the address supplied from outside. On the cycles that follow it can step through the remaining words of an aligned group of four. Only the two least significant address bits move. They step in linear order or in interleaved order, and a static strap input picks which one. The upper bits keep the value captured at the start.

Two start strobes are provided. The processor-side strobe only takes effect while the chip enable is active. The controller-side strobe always takes effect. An advance input steps the counter, and a new address may be loaded on any cycle, so a host that does not want bursts can load an address every cycle. The block also registers a flag that marks the first beat after a load.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and after its release until the first load, addr_out is all zeros and first_beat is 0.
- R2: When ctl_start is 1 at a rising edge, addr_out equals the sampled addr_in from the next cycle, and first_beat is 1. This holds whatever the values of cpu_start and chip_en.
- R3: When cpu_start is 1 at a rising edge with chip_en 1, the address loads as in R2. When chip_en is 0, cpu_start has no effect, and addr_out and first_beat follow R5 or R8 as if it were 0.
- R4: When a load and adv are both 1 in the same cycle, the load wins. addr_out becomes addr_in with no step applied.
- R5: When adv is 1 at an edge with no load, addr_out[AW-1:2] does not change and first_beat becomes 0.
- R6: With order_lin = 1 (linear order), the n-th advance after a load gives addr_out[1:0] = (start + n) mod 4. Here start is addr_in[1:0] as loaded.
- R7: With order_lin = 0 (interleaved order, the default strap level), the n-th advance gives addr_out[1:0] = start XOR (n mod 4). For example, a start of 1 gives the sequence 1,0,3,2.
- R8: When no load happens and adv is 0, addr_out and first_beat keep their values.
- R9: After four advances the low bits return to the start value. The counter wraps within the aligned group of four.
- R10: Loads on consecutive cycles each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | External word address |
| cpu_start | input | 1 | Processor-side burst start, gated by chip_en |
| ctl_start | input | 1 | Controller-side burst start, never gated |
| chip_en | input | 1 | Chip enable qualifying cpu_start |
| adv | input | 1 | Step the burst counter |
| order_lin | input | 1 | Static strap: 1 linear, 0 interleaved |
| addr_out | output | AW | Current word address |
| first_beat | output | 1 | High on the cycle after a load until the first advance |

## Verification
A load and an advance can fall in the same cycle, and the design must ignore the advance. The bench provokes this in three ways: it raises adv together with ctl_start, it raises adv together with an enabled cpu_start, and it raises adv together with cpu_start while chip_en is low. In the last case the advance must take effect. The bench judges each case against a behavioural model that tracks the start address and a step count. Any advance that leaks into a load shows up as an offset in the low bits, or as a cleared first_beat.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cpu_start,
  input  logic          ctl_start,
  input  logic          chip_en,
  input  logic          adv,
  input  logic          order_lin,
  output logic [AW-1:0] addr_out,
  output logic          first_beat
);
  logic [AW-1:0] base_q;
  logic [1:0]    step_q;
  logic          first_q;
  logic          load;
  logic [1:0]    low;

  assign load = ctl_start | (cpu_start & chip_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      step_q  <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      base_q  <= addr_in;
      step_q  <= '0;
      first_q <= 1'b1;
    end else if (adv) begin
      step_q  <= step_q + 2'd1;
      first_q <= 1'b0;
    end
  end

  assign low        = order_lin ? (base_q[1:0] + step_q) : (base_q[1:0] ^ step_q);
  assign addr_out   = {base_q[AW-1:2], low};
  assign first_beat = first_q;
endmodule

module burst_addr_gen_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic          cpu_start,
  input logic          ctl_start,
  input logic          chip_en,
  input logic          adv,
  input logic          order_lin,
  input logic [AW-1:0] addr_out,
  input logic          first_beat
);
  p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start |=> (addr_out == $past(addr_in)) && first_beat);

  p_cpu_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start && chip_en) |=> (addr_out == $past(addr_in)) && first_beat);

  p_gated_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start && !chip_en && !ctl_start && !adv) |=>
      ($stable(first_beat) && ($stable(addr_out) || order_lin != $past(order_lin))));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctl_start && !(cpu_start && chip_en)) |=>
      (addr_out[AW-1:2] == $past(addr_out[AW-1:2])) && !first_beat);

  p_lin_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && order_lin && !ctl_start && !(cpu_start && chip_en)) |=>
      (!order_lin || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  p_intl_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && first_beat && !order_lin && !ctl_start && !(cpu_start && chip_en)) |=>
      (order_lin || addr_out[1:0] == ($past(addr_out[1:0]) ^ 2'b01)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ctl_start && !(cpu_start && chip_en)) |=>
      ($stable(first_beat) && ($stable(addr_out) || order_lin != $past(order_lin))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_start = 1'b0, ctl_start = 1'b0, chip_en = 1'b0, adv = 1'b0, order_lin = 1'b0;
  logic [AW-1:0] addr_out;
  logic          first_beat;

  burst_addr_gen #(.AW(AW)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_base = '0;
  int            m_step = 0;
  bit            m_first = 1'b0;
  string         tag = "R1";

  function automatic logic [AW-1:0] model_addr();
    int lo;
    if (order_lin) lo = (m_base[1:0] + m_step) % 4;
    else lo = m_base[1:0] ^ (m_step % 4);
    return {m_base[AW-1:2], lo[1:0]};
  endfunction

  task automatic compare();
    logic [AW-1:0] e;
    e = model_addr();
    checks++;
    if (addr_out !== e) begin
      fails++;
      $display("FAIL %s addr_out actual %h expected %h", tag, addr_out, e);
    end
    checks++;
    if (first_beat !== m_first) begin
      fails++;
      $display("FAIL %s first_beat actual %b expected %b", tag, first_beat, m_first);
    end
  endtask

  task automatic cyc(input bit c, input bit p, input bit ce, input bit a,
                     input bit lin, input logic [AW-1:0] ad);
    bit ld;
    @(negedge clk);
    compare();
    ctl_start = c; cpu_start = p; chip_en = ce; adv = a; order_lin = lin; addr_in = ad;
    ld = c || (p && ce);
    if (ld) begin
      if (a) tag = "R4";
      else if (c) tag = "R2/R10";
      else tag = "R3/R10";
      m_base = ad; m_step = 0; m_first = 1'b1;
    end else if (a) begin
      m_step = m_step + 1;
      m_first = 1'b0;
      if (m_step % 4 == 0) tag = "R9";
      else if (p) tag = "R3/R5";
      else tag = lin ? "R5/R6" : "R5/R7";
    end else begin
      tag = p ? "R3/R8" : "R8";
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare();
    rst_n = 1'b1;
    cyc(0,0,0,0,0,'0);
    // R7 interleaved burst from start 1: 1,0,3,2 then wrap R9
    cyc(1,0,0,0,0,18'h1_2341);
    for (int i = 0; i < 5; i++) cyc(0,0,0,1,0,'0);
    // R6 linear burst from start 2 via enabled cpu strobe
    cyc(0,1,1,0,1,18'h2_abce);
    for (int i = 0; i < 5; i++) cyc(0,0,0,1,1,'0);
    // R8 hold cycles
    cyc(0,0,1,0,1,18'h3_ffff);
    cyc(0,0,0,0,1,18'h0_0003);
    // R3 gated cpu strobe: ignored, with and without adv
    cyc(1,0,0,0,1,18'h0_1003);
    cyc(0,1,0,0,1,18'h3_0000);
    cyc(0,1,0,1,1,18'h3_0001);
    // R4 load with adv on both strobes, and ctl ignoring chip_en
    cyc(1,1,0,1,0,18'h1_5552);
    cyc(0,0,0,1,0,'0);
    cyc(0,1,1,1,0,18'h0_7773);
    cyc(0,0,0,1,0,'0);
    cyc(0,0,0,1,0,'0);
    // R10 back-to-back loads
    for (int i = 0; i < 6; i++) cyc(i % 2, (i % 2) == 0, 1, 0, 1, AW'(18'h0_0100 + i * 5));
    // mixed traffic
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 8) == 0, ($urandom % 5) == 0, $urandom % 2, $urandom % 2,
          (i / 100) % 2, AW'($urandom));
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule